// File: doc/BRIEF.md
# Key-Locked Configuration Register Bank

This block is a small bank of configuration registers on a plain synchronous bus: address, write enable, write data and read data. Some of the registers refuse writes until software has opened a lock for them. The remaining registers take writes at any time. The register contents drive peripheral controls elsewhere in the chip through a flat output vector.

There are two ways to protect a register. In the first, each guarded register has its own lock word. Writing that word's key opens a short window of a few cycles, and the lock then shuts by itself. In the second, a group of registers is guarded by two kick words. Writes to the group pass only while both kick words hold their keys, and this state has no timeout. A register that is named by a lock slot is governed by that slot alone. A register in the kick group that no slot names follows the kick pair. Any other register is written directly.

All keys, addresses, the register-to-lock assignment, the kick group and the length of the relock window are parameters.

Top module: `kcr_bank`

## Requirements
- R1: A register assigned to a lock slot keeps its value when it is written while that slot is closed. By default, slot i sits at address 16+i, guards register i (i = 0..3) and has the key 32'h6D3C0001+i.
- R2: After a correct key write to a slot, a write to its register is accepted in any of the next RELOCK_WIN cycles (default 4) and discarded after that. Writing the key again restarts the window.
- R3: Writing zero to a lock slot closes it at once, and a following write to its register is discarded.
- R4: A nonzero wrong key written to a slot leaves that slot closed. It does not disturb an open window on a different slot.
- R5: Registers in the kick group (default registers 4 and 5) accept a write only while kick word 0 (address 24) holds 32'h1B7E55AA and kick word 1 (address 25) holds 32'hE48AA155, both at the same time.
- R6: The kick pair has no timeout. It stays open until either kick word is rewritten with any other value, for example zero.
- R7: Registers covered by neither scheme (default 6 and 7) take every write directly.
- R8: Reads are never gated and return data one cycle after the address is presented. Register addresses 0..7 return the stored value. Lock and kick addresses return 1 when open (for a kick word: when it holds its key) and 0 otherwise.
- R9: After reset every register holds zero, every lock is closed, and every address reads 0.
- R10: Addresses that map to nothing read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Word address |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| cfg_out | output | NUM_CFG*DATA_W | All configuration registers; register r occupies bits r*DATA_W and up |

## Verification
A write registers at the clock edge where the strobe is sampled, so cfg_out is checked half a cycle later, at the next falling edge. Read data is registered from the address sampled at that same edge and is checked at the next falling edge. A key written at edge k leaves the window open for data writes sampled at edges k+1 through k+RELOCK_WIN. The bench drives one operation per cycle and sweeps the gap between the key write and the data write from 0 to RELOCK_WIN+1 idle cycles on every slot. The expected accept/reject result is computed from that gap. The kick pair is swept over all nine combinations of empty, correct and wrong values in the two kick words.

// File: rtl/kcr_pkg.sv
// Package for the key-locked register bank.
// Holds the helper that decides, at elaboration, whether a register index
// is named by any lock slot. Assumes 8-bit target fields and at most 32 slots.
package kcr_pkg;

    localparam int TGT_W = 8;

    // True when any of the first n slot targets equals register index r.
    function automatic bit tgt_covers(input logic [255:0] tgt, input int n, input int r);
        for (int i = 0; i < n; i++) begin
            if (tgt[i*TGT_W +: TGT_W] == TGT_W'(r)) return 1'b1;
        end
        return 1'b0;
    endfunction

endpackage

// File: rtl/kcr_lock_slot.sv
// One single-key lock slot.
// Opens for WIN cycles when KEY is written to it. Any other write to it
// (zero or a wrong key) closes it. Assumes WIN >= 1.
module kcr_lock_slot #(
    parameter int          DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY = '1,
    parameter int          WIN    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic [DATA_W-1:0] wdata,
    output logic              open
);
    localparam int CNT_W = $clog2(WIN + 1);

    logic [CNT_W-1:0] remain;

    // Load the window on a key hit, clear on any other hit, else count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (sel) begin
            remain <= (wdata == KEY) ? CNT_W'(WIN) : '0;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign open = (remain != '0);

endmodule

// File: rtl/kcr_kick_pair.sv
// Two kick words that together open the kick-protected group.
// Each word stores only whether it currently holds its key, so any
// write of another value (zero included) drops it. There is no timeout.
module kcr_kick_pair #(
    parameter int                DATA_W = 32,
    parameter logic [DATA_W-1:0] KEY0   = '1,
    parameter logic [DATA_W-1:0] KEY1   = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel0,
    input  logic              sel1,
    input  logic [DATA_W-1:0] wdata,
    output logic [1:0]        held,
    output logic              open
);
    // Track key match of each kick word on its own writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 2'b00;
        end else begin
            if (sel0) held[0] <= (wdata == KEY0);
            if (sel1) held[1] <= (wdata == KEY1);
        end
    end

    assign open = &held;

endmodule

// File: rtl/kcr_cfg_bank.sv
// Configuration register storage with per-register write gating.
// Gating per register: a register named by a lock slot follows that slot;
// otherwise, if it is in KICK_MASK, it follows the kick pair; otherwise it
// is written directly. Assumes register r sits at address CFG_BASE+r.
module kcr_cfg_bank #(
    parameter int                          DATA_W    = 32,
    parameter int                          ADDR_W    = 5,
    parameter int                          NUM_CFG   = 8,
    parameter int                          NUM_LOCKS = 4,
    parameter int                          CFG_BASE  = 0,
    parameter logic [NUM_LOCKS*8-1:0]      LOCK_TGT  = '0,
    parameter logic [NUM_CFG-1:0]          KICK_MASK = '0
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        we,
    input  logic [ADDR_W-1:0]           addr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [NUM_LOCKS-1:0]        lock_open,
    input  logic                        kick_open,
    output logic [NUM_CFG*DATA_W-1:0]   cfg
);
    for (genvar r = 0; r < NUM_CFG; r++) begin : g_reg
        localparam bit COVERED = kcr_pkg::tgt_covers(256'(LOCK_TGT), NUM_LOCKS, r);

        logic [NUM_LOCKS-1:0] slot_ok;
        logic                 permit;
        logic                 hit;

        for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_slot
            localparam bit MINE = (LOCK_TGT[i*8 +: 8] == 8'(r));
            assign slot_ok[i] = MINE && lock_open[i];
        end

        if (COVERED) begin : g_locked
            assign permit = |slot_ok;
        end else if (KICK_MASK[r]) begin : g_kicked
            assign permit = kick_open;
        end else begin : g_direct
            assign permit = 1'b1;
        end

        assign hit = we && (addr == ADDR_W'(CFG_BASE + r));

        // Store the write data when the register is addressed and permitted.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[r*DATA_W +: DATA_W] <= '0;
            end else if (hit && permit) begin
                cfg[r*DATA_W +: DATA_W] <= wdata;
            end
        end
    end

endmodule

// File: rtl/kcr_bank.sv
// Top of the key-locked configuration register bank.
// Decodes the bus address into config, lock-slot and kick-word selects,
// instantiates the slots, the kick pair and the storage, and registers the
// read data (one-cycle latency). Unmapped addresses read zero.
// Assumes the three address ranges do not overlap.
module kcr_bank #(
    parameter int                          DATA_W     = 32,
    parameter int                          ADDR_W     = 5,
    parameter int                          NUM_CFG    = 8,
    parameter int                          NUM_LOCKS  = 4,
    parameter int                          RELOCK_WIN = 4,
    parameter int                          CFG_BASE   = 0,
    parameter int                          LOCK_BASE  = 16,
    parameter int                          KICK0_ADDR = 24,
    parameter int                          KICK1_ADDR = 25,
    parameter logic [NUM_LOCKS*8-1:0]      LOCK_TGT   = {8'd3, 8'd2, 8'd1, 8'd0},
    parameter logic [NUM_LOCKS*DATA_W-1:0] LOCK_KEYS  = {32'h6D3C0004, 32'h6D3C0003,
                                                         32'h6D3C0002, 32'h6D3C0001},
    parameter logic [DATA_W-1:0]           KICK_KEY0  = 32'h1B7E55AA,
    parameter logic [DATA_W-1:0]           KICK_KEY1  = 32'hE48AA155,
    parameter logic [NUM_CFG-1:0]          KICK_MASK  = 8'b0011_0000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_we,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [NUM_CFG*DATA_W-1:0] cfg_out
);
    logic [NUM_LOCKS-1:0] lock_open;
    logic [1:0]           kick_held;
    logic                 kick_open;
    logic                 kick_sel0;
    logic                 kick_sel1;
    logic [DATA_W-1:0]    rd_next;

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
        logic sel;
        assign sel = bus_we && (bus_addr == ADDR_W'(LOCK_BASE + i));

        kcr_lock_slot #(
            .DATA_W (DATA_W),
            .KEY    (LOCK_KEYS[i*DATA_W +: DATA_W]),
            .WIN    (RELOCK_WIN)
        ) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (sel),
            .wdata (bus_wdata),
            .open  (lock_open[i])
        );
    end

    assign kick_sel0 = bus_we && (bus_addr == ADDR_W'(KICK0_ADDR));
    assign kick_sel1 = bus_we && (bus_addr == ADDR_W'(KICK1_ADDR));

    kcr_kick_pair #(
        .DATA_W (DATA_W),
        .KEY0   (KICK_KEY0),
        .KEY1   (KICK_KEY1)
    ) u_kick (
        .clk   (clk),
        .rst_n (rst_n),
        .sel0  (kick_sel0),
        .sel1  (kick_sel1),
        .wdata (bus_wdata),
        .held  (kick_held),
        .open  (kick_open)
    );

    kcr_cfg_bank #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .NUM_CFG   (NUM_CFG),
        .NUM_LOCKS (NUM_LOCKS),
        .CFG_BASE  (CFG_BASE),
        .LOCK_TGT  (LOCK_TGT),
        .KICK_MASK (KICK_MASK)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .lock_open (lock_open),
        .kick_open (kick_open),
        .cfg       (cfg_out)
    );

    // Select the read value for the presented address.
    always_comb begin
        rd_next = '0;
        for (int r = 0; r < NUM_CFG; r++) begin
            if (bus_addr == ADDR_W'(CFG_BASE + r)) rd_next = cfg_out[r*DATA_W +: DATA_W];
        end
        for (int i = 0; i < NUM_LOCKS; i++) begin
            if (bus_addr == ADDR_W'(LOCK_BASE + i)) rd_next = DATA_W'(lock_open[i]);
        end
        if (bus_addr == ADDR_W'(KICK0_ADDR)) rd_next = DATA_W'(kick_held[0]);
        if (bus_addr == ADDR_W'(KICK1_ADDR)) rd_next = DATA_W'(kick_held[1]);
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_next;
    end

endmodule

// File: rtl/kcr_bank_chk.sv
// Assertion checker for kcr_bank, attached by bind below.
// Observes the bus, the per-slot open flags, the kick open flag and the
// register outputs. Keeps its own count of cycles since each key write.
module kcr_bank_chk #(
    parameter int                          DATA_W     = 32,
    parameter int                          ADDR_W     = 5,
    parameter int                          NUM_CFG    = 8,
    parameter int                          NUM_LOCKS  = 4,
    parameter int                          RELOCK_WIN = 4,
    parameter int                          CFG_BASE   = 0,
    parameter int                          LOCK_BASE  = 16,
    parameter int                          KICK0_ADDR = 24,
    parameter int                          KICK1_ADDR = 25,
    parameter logic [NUM_LOCKS*8-1:0]      LOCK_TGT   = '0,
    parameter logic [NUM_LOCKS*DATA_W-1:0] LOCK_KEYS  = '0,
    parameter logic [NUM_CFG-1:0]          KICK_MASK  = '0
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [ADDR_W-1:0]         bus_addr,
    input logic                      bus_we,
    input logic [DATA_W-1:0]         bus_wdata,
    input logic [NUM_LOCKS-1:0]      lock_open,
    input logic                      kick_open,
    input logic [NUM_CFG*DATA_W-1:0] cfg_out
);
    localparam int SW = $clog2(RELOCK_WIN + 2) + 1;

    for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_slot
        localparam int                TR  = int'(LOCK_TGT[i*8 +: 8]);
        localparam logic [DATA_W-1:0] KEY = LOCK_KEYS[i*DATA_W +: DATA_W];

        logic          lk_hit;
        logic [SW-1:0] since;
        assign lk_hit = bus_we && (bus_addr == ADDR_W'(LOCK_BASE + i));

        // Count cycles since the last correct key write, saturating.
        always_ff @(posedge clk) begin
            if (!rst_n)                        since <= SW'(RELOCK_WIN + 1);
            else if (lk_hit && bus_wdata == KEY) since <= SW'(1);
            else if (since <= SW'(RELOCK_WIN)) since <= since + 1'b1;
        end

        AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_we && bus_addr == ADDR_W'(CFG_BASE + TR) && !lock_open[i])
            |=> $stable(cfg_out[TR*DATA_W +: DATA_W])); // R1
        AST_RELOCK_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            lock_open[i] |-> (since <= SW'(RELOCK_WIN))); // R2
        AST_ZERO_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_hit && bus_wdata == '0) |=> !lock_open[i]); // R3
        AST_WRONG_KEY_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
            (lk_hit && bus_wdata != KEY) |=> !lock_open[i]); // R4
    end

    for (genvar r = 0; r < NUM_CFG; r++) begin : g_reg
        localparam bit COVERED = kcr_pkg::tgt_covers(256'(LOCK_TGT), NUM_LOCKS, r);
        if (!COVERED && KICK_MASK[r]) begin : g_kick
            AST_KICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && bus_addr == ADDR_W'(CFG_BASE + r) && !kick_open)
                |=> $stable(cfg_out[r*DATA_W +: DATA_W])); // R5
        end else if (!COVERED) begin : g_direct
            AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && bus_addr == ADDR_W'(CFG_BASE + r))
                |=> (cfg_out[r*DATA_W +: DATA_W] == $past(bus_wdata))); // R7
        end
    end

    AST_KICK_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_open && !(bus_we && (bus_addr == ADDR_W'(KICK0_ADDR) ||
                                   bus_addr == ADDR_W'(KICK1_ADDR))))
        |=> kick_open); // R6

endmodule

bind kcr_bank kcr_bank_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .NUM_CFG    (NUM_CFG),
    .NUM_LOCKS  (NUM_LOCKS),
    .RELOCK_WIN (RELOCK_WIN),
    .CFG_BASE   (CFG_BASE),
    .LOCK_BASE  (LOCK_BASE),
    .KICK0_ADDR (KICK0_ADDR),
    .KICK1_ADDR (KICK1_ADDR),
    .LOCK_TGT   (LOCK_TGT),
    .LOCK_KEYS  (LOCK_KEYS),
    .KICK_MASK  (KICK_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .lock_open (lock_open),
    .kick_open (kick_open),
    .cfg_out   (cfg_out)
);

// File: tb/kcr_bank_tb.sv
// Self-checking bench for kcr_bank with default parameters.
module kcr_bank_tb;
    localparam int WIN = 4;
    localparam logic [31:0] KK0 = 32'h1B7E55AA;
    localparam logic [31:0] KK1 = 32'hE48AA155;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [255:0] cfg_out;

    logic [31:0] exp_cfg [8];
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    kcr_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_out(cfg_out)
    );

    function automatic logic [31:0] lkey(input int i);
        return 32'h6D3C0001 + 32'(i);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // Each task is entered at a falling edge and returns at the next one.
    task automatic wr(input int a, input logic [31:0] d);
        bus_addr = 5'(a); bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle();
        bus_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        bus_addr = 5'(a); bus_we = 1'b0;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic check_cfg(input string req);
        for (int r = 0; r < 8; r++) check(req, cfg_out[r*32 +: 32], exp_cfg[r]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] d;
        for (int r = 0; r < 8; r++) exp_cfg[r] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: every address reads zero after reset
        for (int a = 0; a < 32; a++) begin
            rd(a, v);
            check("R9", v, 32'd0);
        end
        check_cfg("R9");

        // R1 and R2: gap sweep on every lock slot
        for (int i = 0; i < 4; i++) begin
            for (int g = 0; g <= WIN + 1; g++) begin
                d = 32'hA5000000 | 32'(i << 8) | 32'(g);
                wr(i, ~d);
                check("R1", cfg_out[i*32 +: 32], exp_cfg[i]);
                wr(16 + i, lkey(i));
                for (int k = 0; k < g; k++) idle();
                wr(i, d);
                if (g + 1 <= WIN) exp_cfg[i] = d;
                check("R2", cfg_out[i*32 +: 32], exp_cfg[i]);
                wr(16 + i, 32'd0);
            end
        end

        // R2: rewriting the key restarts the window
        wr(17, lkey(1));
        for (int k = 0; k < 3; k++) idle();
        wr(17, lkey(1));
        for (int k = 0; k < 3; k++) idle();
        wr(1, 32'h0BAD0001);
        exp_cfg[1] = 32'h0BAD0001;
        check("R2", cfg_out[32 +: 32], exp_cfg[1]);
        wr(17, 32'd0);

        // R8 and R3: lock readback, zero closes immediately
        wr(18, lkey(2));
        rd(18, v);
        check("R8", v, 32'd1);
        wr(18, 32'd0);
        rd(18, v);
        check("R3", v, 32'd0);
        wr(2, 32'h33333333);
        check("R3", cfg_out[64 +: 32], exp_cfg[2]);

        // R4: wrong key on slot 1 leaves it shut and slot 0 still open
        wr(16, lkey(0));
        wr(17, lkey(1) ^ 32'h00000100);
        rd(16, v);
        check("R4", v, 32'd1);
        wr(0, 32'h44440000);
        exp_cfg[0] = 32'h44440000;
        wr(1, 32'h44440001);
        check_cfg("R4");
        rd(17, v);
        check("R4", v, 32'd0);
        wr(16, 32'd0);

        // R5: kick pair sweep over empty, correct and wrong words
        for (int a = 0; a < 3; a++) begin
            for (int b = 0; b < 3; b++) begin
                wr(24, (a == 0) ? 32'd0 : (a == 1) ? KK0 : (KK0 ^ 32'd1));
                wr(25, (b == 0) ? 32'd0 : (b == 1) ? KK1 : (KK1 ^ 32'h80000000));
                rd(24, v);
                check("R8", v, (a == 1) ? 32'd1 : 32'd0);
                rd(25, v);
                check("R8", v, (b == 1) ? 32'd1 : 32'd0);
                d = 32'hC0000000 | 32'(a * 16 + b);
                wr(4, d);
                wr(5, ~d);
                if (a == 1 && b == 1) begin
                    exp_cfg[4] = d;
                    exp_cfg[5] = ~d;
                end
                check_cfg("R5");
                wr(24, 32'd0);
                wr(25, 32'd0);
            end
        end

        // R6: kick pair holds over a long gap, then a zero shuts it
        wr(24, KK0);
        wr(25, KK1);
        for (int k = 0; k < 20; k++) idle();
        wr(5, 32'h66660005);
        exp_cfg[5] = 32'h66660005;
        check("R6", cfg_out[160 +: 32], exp_cfg[5]);
        wr(24, 32'd0);
        wr(5, 32'h66660099);
        check("R6", cfg_out[160 +: 32], exp_cfg[5]);
        wr(25, 32'd0);

        // R7: direct registers under several patterns
        for (int p = 0; p < 4; p++) begin
            d = 32'h01010101 << p;
            wr(6, d);
            wr(7, ~d);
            exp_cfg[6] = d;
            exp_cfg[7] = ~d;
            check("R7", cfg_out[192 +: 32], exp_cfg[6]);
            check("R7", cfg_out[224 +: 32], exp_cfg[7]);
        end

        // R10: unmapped addresses
        wr(10, 32'hFFFFFFFF);
        wr(31, 32'h12345678);
        check_cfg("R10");
        rd(10, v);
        check("R10", v, 32'd0);
        rd(31, v);
        check("R10", v, 32'd0);

        // R8: ungated readback of every register and closed locks
        for (int r = 0; r < 8; r++) begin
            rd(r, v);
            check("R8", v, exp_cfg[r]);
        end
        for (int i = 0; i < 4; i++) begin
            rd(16 + i, v);
            check("R8", v, 32'd0);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule